// File: doc/BRIEF.md
# Multichannel Edge-Aligned PWM Timer

This block produces edge-aligned pulse-width-modulated outputs on a set of channels that all share one time base. A 16-bit up-counter, slowed by a power-of-two prescaler, counts from zero up to a programmable period limit and then returns to zero. Each channel compares the shared count against its own threshold. Each channel also has a small control field that enables it and picks normal or inverted polarity.

Software reaches the block over a simple single-cycle register bus. A write is taken on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. While the counter is stopped, period and threshold writes land at once. While it runs, they are parked in a shadow copy and applied only when the counter wraps to zero, so a period is never built from a mix of old and new settings. Read-back always shows the value in use. Polarity and enable changes act at once.

Register offsets, in bytes: identification 0x04, global 0x08, timer control 0x10, count 0x14, period limit 0x18, channel n control 0x20+8n, channel n threshold 0x24+8n. Addresses that do not decode read as zero.

Top module: `edge_pwm_timer`

## Requirements
- R1: After reset the timer control reads 0 (counter stopped, prescale 0), the count reads 0, the period limit reads 0xFFFF, every channel control and threshold reads 0, and every `pwm_o` bit is 0.
- R2: Bits [7:0] of the identification register (0x04) read the channel count N_CH, and its upper bits read 0. The global register (0x08) reads 0.
- R3: In timer control (0x10), bits [2:0] are a prescale exponent PS, and bits [4:3] are the clock mode. Mode 01 advances the count once every 2^PS clocks. Any other mode holds the count. Bit 5 always reads 0 and writes to it are ignored.
- R4: While running, the count (read at 0x14) steps by one per prescaled tick. On a tick where it is at or above the period limit, it goes to 0 instead, and this marks a period start.
- R5: While the clock mode is not 01, a write to the period limit or to a channel threshold is visible on read-back in the next cycle and acts on the outputs at once.
- R6: While the clock mode is 01, a write to the period limit or to a threshold does not change the value in use, and the read-back keeps showing the old value. The written value takes over at the next period start. It also takes over if the counter is stopped first.
- R7: In channel control, bit 5 enables the channel. Bits [3:2] select the edge behaviour: 10 is normal and 01 is inverted. Bit 4 is stored and read back. A channel output is 0 unless bit 5 is 1 and bits [3:2] are 10 or 01.
- R8: In normal polarity the output is 1 while count < threshold and 0 otherwise. A threshold of 0 keeps it low, and a threshold above the period limit keeps it high. Inverted polarity gives the complement.
- R9: A write to channel control changes that channel's output from the next cycle on. It does not wait for a period start.
- R10: Channel control bit 7 is a match flag. It is set while the counter runs and the count equals the channel threshold. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged. When a set and a clear happen in the same cycle, the set wins.
- R11: Channels share the count but keep independent thresholds and controls. Changing one channel does not alter another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe, taken at the rising edge |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pwm_o | output | N_CH | Channel outputs |

## Verification
On every cycle, the assertions check the following. A stopped counter holds its count, a running one steps by one or wraps to zero after a period start, and a shadowed value stays unchanged while running between period starts. A stopped-time write is adopted in the next cycle. A match flag holds until cleared, a disabled channel stays low, and a zero threshold in normal polarity stays low. The bench scenarios show the rest. They measure duty cycles over whole periods for several thresholds, polarities and channels. They read back values before and after a deferred load, check the prescaled counting rate, and observe that polarity and enable changes reach the output in the very next cycle.

// File: rtl/ept_pkg.sv
package ept_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_IDENT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_GLOBAL = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_TCTRL  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CHBASE = 8'h20;

    typedef enum logic [1:0] {
        CLK_HALT  = 2'b00,
        CLK_RUN   = 2'b01,
        CLK_RSV_A = 2'b10,
        CLK_RSV_B = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_INV  = 2'b01,
        EDGE_NORM = 2'b10,
        EDGE_RSV  = 2'b11
    } edge_sel_e;

    // timer control: bits [4:3] mode, bits [2:0] prescale exponent
    typedef struct packed {
        clk_mode_e  mode;
        logic [2:0] ps;
    } tctrl_t;

    // channel control: bit 5 enable, bit 4 spare mode bit, bits [3:2] edge
    typedef struct packed {
        logic      en;
        logic      spare;
        edge_sel_e edge_sel;
    } chctrl_t;

    function automatic logic chan_active(chctrl_t c);
        return c.en && (c.edge_sel == EDGE_NORM || c.edge_sel == EDGE_INV);
    endfunction

    function automatic logic [DATA_W-1:0] pack_chctrl(logic flag, chctrl_t c);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[7]   = flag;
        w[5:2] = c;
        return w;
    endfunction

endpackage

// File: rtl/ept_shadow.sv
module ept_shadow #(
    parameter int            W       = 16,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         running,
    input  logic         load,
    output logic [W-1:0] q
);

    logic [W-1:0] buf_q;
    logic         pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= RST_VAL;
            buf_q  <= '0;
            pend_q <= 1'b0;
        end else if (we && !running) begin
            q      <= wdata;
            pend_q <= 1'b0;
        end else begin
            if (pend_q && (load || !running)) begin
                q      <= buf_q;
                pend_q <= 1'b0;
            end
            if (we) begin
                buf_q  <= wdata;
                pend_q <= 1'b1;
            end
        end
    end

    // R5: a stopped-time write is in use the next cycle
    p_stopped_write_r5: assert property (@(posedge clk) disable iff (rst)
        (we && !running) |=> (q == $past(wdata)));

    // R6: nothing changes the value in use between period starts while running
    p_running_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (running && !load && !$past(rst)) |=> $stable(q));

endmodule

// File: rtl/ept_timebase.sv
module ept_timebase
    import ept_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  tctrl_t           ctrl_wdata,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_wdata,
    output tctrl_t           ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] period_act,
    output logic             running,
    output logic             period_start
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic             tick;

    assign running      = (ctrl_q.mode == CLK_RUN);
    assign div_lim      = (DIV_W'(1) << ctrl_q.ps) - DIV_W'(1);
    assign tick         = running && (div_q >= div_lim);
    assign period_start = tick && (cnt_q >= period_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{mode: CLK_HALT, ps: '0};
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !running || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (period_start) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    ept_shadow #(
        .W       (CNT_W),
        .RST_VAL ({CNT_W{1'b1}})
    ) u_period (
        .clk     (clk),
        .rst     (rst),
        .we      (period_we),
        .wdata   (period_wdata),
        .running (running),
        .load    (period_start),
        .q       (period_act)
    );

    // R3: a halted counter holds its value
    p_halt_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (!running && !$past(rst)) |=> $stable(cnt_q));

    // R4: below the limit a tick advances the count by exactly one
    p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && (cnt_q < period_act)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R4: a period start returns the count to zero
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
        period_start |=> (cnt_q == '0));

endmodule

// File: rtl/ept_channel.sv
module ept_channel
    import ept_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              val_we,
    input  logic [CNT_W-1:0]  val_wdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              running,
    input  logic              period_start,
    output logic [DATA_W-1:0] ctl_rd,
    output logic [CNT_W-1:0]  val_act,
    output logic              pwm_o
);

    chctrl_t ctl_q;
    logic    flag_q;
    logic    below;
    logic    flag_clr;

    assign flag_clr = ctl_we && ctl_wdata[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{en: 1'b0, spare: 1'b0, edge_sel: EDGE_OFF};
        end else if (ctl_we) begin
            ctl_q <= chctrl_t'(ctl_wdata[5:2]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (running && (cnt_i == val_act)) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    ept_shadow #(
        .W       (CNT_W),
        .RST_VAL ('0)
    ) u_thresh (
        .clk     (clk),
        .rst     (rst),
        .we      (val_we),
        .wdata   (val_wdata),
        .running (running),
        .load    (period_start),
        .q       (val_act)
    );

    assign below  = (cnt_i < val_act);
    assign ctl_rd = pack_chctrl(flag_q, ctl_q);

    always_comb begin
        pwm_o = 1'b0;
        if (chan_active(ctl_q)) begin
            pwm_o = (ctl_q.edge_sel == EDGE_INV) ? !below : below;
        end
    end

    // R10: the flag only falls through a write of 1 to bit 7
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q);

    // R7: a channel whose enable bit is clear stays low
    p_disabled_low_r7: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.en |-> !pwm_o);

    // R8: zero threshold in normal polarity never drives high
    p_zero_low_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.edge_sel == EDGE_NORM && val_act == '0) |-> !pwm_o);

endmodule

// File: rtl/edge_pwm_timer.sv
module edge_pwm_timer
    import ept_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   pwm_o
);

    localparam int IDX_W = ADDR_W - 3;

    tctrl_t            tctrl;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  period_act;
    logic              running;
    logic              period_start;

    logic [ADDR_W-1:0] ch_off;
    logic [IDX_W-1:0]  ch_idx;
    logic              ch_valid;

    logic [DATA_W-1:0] ctl_rd  [N_CH];
    logic [CNT_W-1:0]  val_act [N_CH];

    assign ch_off   = bus_addr - OFS_CHBASE;
    assign ch_idx   = ch_off[ADDR_W-1:3];
    assign ch_valid = (bus_addr >= OFS_CHBASE) && (bus_addr[1:0] == 2'b00)
                      && (int'(ch_idx) < N_CH);

    ept_timebase #(
        .CNT_W (CNT_W),
        .PS_W  (PS_W)
    ) u_timebase (
        .clk          (clk),
        .rst          (rst),
        .ctrl_we      (bus_we && bus_addr == OFS_TCTRL),
        .ctrl_wdata   (tctrl_t'(bus_wdata[4:0])),
        .period_we    (bus_we && bus_addr == OFS_PERIOD),
        .period_wdata (bus_wdata[CNT_W-1:0]),
        .ctrl_q       (tctrl),
        .cnt_q        (cnt),
        .period_act   (period_act),
        .running      (running),
        .period_start (period_start)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic sel;
        assign sel = bus_we && ch_valid && (ch_idx == IDX_W'(g));

        ept_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk          (clk),
            .rst          (rst),
            .ctl_we       (sel && !bus_addr[2]),
            .ctl_wdata    (bus_wdata),
            .val_we       (sel && bus_addr[2]),
            .val_wdata    (bus_wdata[CNT_W-1:0]),
            .cnt_i        (cnt),
            .running      (running),
            .period_start (period_start),
            .ctl_rd       (ctl_rd[g]),
            .val_act      (val_act[g]),
            .pwm_o        (pwm_o[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (ch_valid) begin
            for (int i = 0; i < N_CH; i++) begin
                if (ch_idx == IDX_W'(i)) begin
                    bus_rdata = bus_addr[2] ? DATA_W'(val_act[i]) : ctl_rd[i];
                end
            end
        end else begin
            case (bus_addr)
                OFS_IDENT:  bus_rdata = DATA_W'(8'(N_CH));
                OFS_GLOBAL: bus_rdata = '0;
                OFS_TCTRL:  bus_rdata = DATA_W'(tctrl);
                OFS_COUNT:  bus_rdata = DATA_W'(cnt);
                OFS_PERIOD: bus_rdata = DATA_W'(period_act);
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R3: timer control bit 5 never reads back as 1
    p_no_center_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_TCTRL) |-> (bus_rdata[DATA_W-1:5] == '0));

endmodule

// File: tb/edge_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module edge_pwm_timer_tb_top;

    localparam int N_CH = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic            we;
    logic [7:0]      addr;
    logic [31:0]     wdata;
    logic [31:0]     rdata;
    logic [N_CH-1:0] pwm;

    always #2.5 clk = ~clk;

    edge_pwm_timer #(.N_CH(N_CH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .pwm_o     (pwm)
    );

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } item_t;

    item_t       exp_q[$];
    logic [31:0] obs;
    event        obs_ev;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    // monitor: pops the expected item and compares with the observation
    initial begin
        forever begin
            item_t it;
            @(obs_ev);
            it = exp_q.pop_front();
            total++;
            if (obs !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%0h expected=%0h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        obs = act;
        exp_q.push_back('{tag, exp});
        -> obs_ev;
        #0.1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.2;
        d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic count_high(input int ch, input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.2;
            if (pwm[ch]) k++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, c1, c2;
        int k;
        int mx;
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 tctrl", 8'h10, 32'h0);
        rd_chk("R1 count", 8'h14, 32'h0);
        rd_chk("R1 period", 8'h18, 32'hFFFF);
        rd_chk("R1 ch0 ctl", 8'h20, 32'h0);
        rd_chk("R1 ch0 val", 8'h24, 32'h0);
        check("R1 pwm", 32'(pwm), 32'h0);

        // R2 identification and global
        rd_chk("R2 ident", 8'h04, N_CH);
        rd_chk("R2 global", 8'h08, 32'h0);

        // R3 bit 5 ignored
        wr(8'h10, 32'h20);
        rd_chk("R3 bit5 reads 0", 8'h10, 32'h0);

        // R5 stopped writes are immediate
        wr(8'h18, 32'd9);
        rd_chk("R5 period immediate", 8'h18, 32'd9);
        wr(8'h24, 32'd3);
        rd_chk("R5 val immediate", 8'h24, 32'd3);
        wr(8'h20, 32'h28);
        wr(8'h2C, 32'd7);
        wr(8'h28, 32'h28);
        check("R8 stopped cnt0<3 high", 32'(pwm[0]), 32'h1);
        idle(5);
        rd_chk("R3 halted count holds", 8'h14, 32'h0);

        // start, prescale 0
        wr(8'h10, 32'h08);
        count_high(0, 40, k);
        check("R8 duty val3 mod9", k, 12);
        count_high(1, 40, k);
        check("R11 ch1 duty val7", k, 28);

        // R4 counter range and stepping
        mx = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            rd(8'h14, d);
            if (int'(d) > mx) mx = int'(d);
        end
        check("R4 count max equals limit", mx, 9);
        rd(8'h14, c1);
        @(negedge clk);
        rd(8'h14, c2);
        check("R4 step or wrap", c2, (c1 + 1) % 10);

        // R6 buffered threshold
        wr(8'h24, 32'd5);
        rd_chk("R6 val still old", 8'h24, 32'd3);
        idle(12);
        rd_chk("R6 val loaded", 8'h24, 32'd5);
        count_high(0, 40, k);
        check("R6 duty after load", k, 20);

        // R6 buffered period
        wr(8'h18, 32'd19);
        rd_chk("R6 period still old", 8'h18, 32'd9);
        idle(12);
        rd_chk("R6 period loaded", 8'h18, 32'd19);
        count_high(0, 40, k);
        check("R6 duty with period 19", k, 10);
        wr(8'h18, 32'd9);
        idle(25);

        // R9 polarity change is immediate
        wr(8'h24, 32'd2);
        idle(12);
        wr(8'h20, 32'h24);
        rd(8'h14, c1);
        check("R9 inverted next cycle", 32'(pwm[0]), (c1 < 2) ? 32'h0 : 32'h1);
        count_high(0, 40, k);
        check("R8 inverted duty", k, 32);

        // R7 disable and reserved encodings
        wr(8'h20, 32'h00);
        check("R9 disable next cycle", 32'(pwm[0]), 32'h0);
        count_high(0, 40, k);
        check("R7 disabled low", k, 0);
        count_high(1, 40, k);
        check("R11 ch1 unaffected", k, 28);
        wr(8'h20, 32'h2C);
        count_high(0, 40, k);
        check("R7 edge 11 low", k, 0);
        wr(8'h20, 32'h08);
        count_high(0, 40, k);
        check("R7 no enable low", k, 0);
        wr(8'h20, 32'h38);
        rd_chk("R7 spare bit stored", 8'h20, 32'hB8);

        // R8 boundaries
        wr(8'h20, 32'h28);
        wr(8'h24, 32'd0);
        idle(12);
        count_high(0, 40, k);
        check("R8 zero threshold low", k, 0);
        wr(8'h24, 32'd12);
        idle(12);
        count_high(0, 40, k);
        check("R8 above limit high", k, 40);

        // R3 prescaler rate
        wr(8'h18, 32'd1000);
        idle(12);
        wr(8'h10, 32'h0B);
        idle(4);
        rd(8'h14, c1);
        idle(16);
        rd(8'h14, c2);
        check("R3 two ticks per 16 clocks at PS3", c2 - c1, 2);

        // R10 match flag
        wr(8'h10, 32'h00);
        rd(8'h14, c1);
        wr(8'h24, c1 + 1);
        wr(8'h20, 32'hA8);
        rd_chk("R10 flag cleared", 8'h20, 32'h28);
        wr(8'h10, 32'h08);
        idle(5);
        rd_chk("R10 flag set on match", 8'h20, 32'hA8);
        wr(8'h20, 32'h28);
        rd_chk("R10 write 0 keeps flag", 8'h20, 32'hA8);
        wr(8'h20, 32'hA8);
        rd_chk("R10 clear while running", 8'h20, 32'h28);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule